// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces an active-low composite sync signal for a 625-line monochrome raster running at 50 fields per second. It runs from a 4 MHz clock. A 7-bit prescaler divides the clock by 128 to make a 32 us half-line tick. A half-line sequencer then picks one pulse shape for each half-line: a normal horizontal sync, a narrow equalizing pulse, a broad vertical pulse with a serration notch, or no pulse at all. Equalizing pulses, broad pulses and the half-line offset of the second field all come from this one half-line index. No separate line counter or frame counter is used.

The generator also outputs a blanking flag, a field-parity flag, the half-line index within the frame and the line index derived from it. When the mode input is high, the block makes a simpler progressive raster of 312 whole lines with no half-line offset. In that mode the vertical interval is one long low stretch lasting three lines. The stretch is notched high at the end of each line, so that a falling edge still occurs at every line start.

Top module: `csync_gen`

## Requirements
- R1: While reset is asserted, the block drives these values: `csync_no` high, `blank_o` high, `field_o` low, and `hline_o` and `line_o` zero.
- R2: The half-line index `hline_o` advances by one every 128 clocks. It wraps to 0 after 1249 in interlaced mode and after 623 in progressive mode.
- R3: Outside the vertical interval, an even half-line (a full-line start) drives `csync_no` low for its first 19 clocks. An odd half-line leaves `csync_no` high throughout.
- R4: In interlaced mode, field-relative half-lines 0 to 4 and 10 to 14 are equalizing half-lines. Each one drives `csync_no` low for its first 9 clocks.
- R5: In interlaced mode, field-relative half-lines 5 to 9 are broad half-lines. Each one drives `csync_no` low for 109 clocks and then high for 19 clocks.
- R6: `field_o` is low for half-lines 0 to 624 and high for half-lines 625 to 1249. The second field therefore begins on a mid-line half-line, and its relative index is `hline_o` minus 625. In progressive mode `field_o` stays low.
- R7: `line_o` equals `hline_o` divided by 2.
- R8: `blank_o` is high during the first 50 half-lines of each field. It is also high during the first 48 clocks of every even half-line.
- R9: In progressive mode, half-lines 0 to 5 form the vertical pulse. An even half-line is low for all 128 clocks, and an odd half-line is low for 109 clocks and then high for 19 clocks. All other half-lines follow R3.
- R10: `csync_no` and `blank_o` are registered. Each reflects the half-line and clock phase of the previous clock. The counters reflect the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_i | input | 1 | 1 selects the progressive raster, 0 selects interlaced |
| csync_no | output | 1 | Composite sync, active low |
| blank_o | output | 1 | Blanking flag |
| field_o | output | 1 | Field parity: 1 means the second field |
| hline_o | output | 11 | Half-line index within the frame |
| line_o | output | 10 | Line index (`hline_o` / 2) |

## Verification
The hardest condition to reach is the start of the second field. It needs 625 half-lines, or 80,000 clocks, of free running after reset. At that point a mid-line half-line must open a block of equalizing pulses rather than stay silent.

The bench runs one full interlaced frame and goes past its wrap. On every clock it compares each output with a model indexed by the number of clocks since reset. The field-two entry, the wrap back to half-line 0 and every pulse edge are therefore all covered.

A shorter progressive run checks the notched three-line vertical pulse.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [2:0] {
    PT_NONE,
    PT_HSYNC,
    PT_EQ,
    PT_BROAD,
    PT_VLOW
  } pulse_e;
endpackage

// File: rtl/csync_div.sv
module csync_div #(
  parameter int DIV_BITS = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [DIV_BITS-1:0] cnt_o,
  output logic                tick_o
);
  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign tick_o = &cnt_q;  // carry out

  AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_o == '0));  // R2
endmodule

// File: rtl/csync_seq.sv
module csync_seq
  import csync_pkg::*;
#(
  parameter int FRAME_HL   = 1250,
  parameter int PROG_LINES = 312,
  parameter int EQ_HL      = 5,
  parameter int BROAD_HL   = 5,
  parameter int PROG_VS_LN = 3,
  parameter int VBL_HL     = 50,
  parameter int HL_W       = $clog2(FRAME_HL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            prog_i,
  output logic [HL_W-1:0] hl_o,
  output logic            field_o,
  output logic            vblank_o,
  output pulse_e          ptype_o
);
  localparam int FIELD_HL = FRAME_HL / 2;
  localparam int PROG_HL  = 2 * PROG_LINES;
  localparam int PVS_HL   = 2 * PROG_VS_LN;

  logic [HL_W-1:0] hl_q, hl_d, hl_last, fi;
  logic            field_q;

  assign hl_last = prog_i ? HL_W'(PROG_HL - 1) : HL_W'(FRAME_HL - 1);
  assign hl_d    = (hl_q >= hl_last) ? '0 : hl_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hl_q    <= '0;
      field_q <= 1'b0;
    end else if (tick_i) begin
      hl_q    <= hl_d;
      field_q <= !prog_i && (hl_d >= HL_W'(FIELD_HL));
    end
  end

  assign fi = field_q ? hl_q - HL_W'(FIELD_HL) : hl_q;

  always_comb begin
    ptype_o = hl_q[0] ? PT_NONE : PT_HSYNC;
    if (prog_i) begin
      if (fi < HL_W'(PVS_HL)) ptype_o = hl_q[0] ? PT_BROAD : PT_VLOW;
    end else begin
      if (fi < HL_W'(EQ_HL))                        ptype_o = PT_EQ;
      else if (fi < HL_W'(EQ_HL + BROAD_HL))        ptype_o = PT_BROAD;
      else if (fi < HL_W'(2 * EQ_HL + BROAD_HL))    ptype_o = PT_EQ;
    end
  end

  assign vblank_o = fi < HL_W'(VBL_HL);
  assign hl_o     = hl_q;
  assign field_o  = field_q;

  AST_HL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (hl_q == $past(hl_q) + 1'b1) || (hl_q == '0));  // R2
  AST_HL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(hl_q));  // R2
  AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_q |-> (hl_q >= HL_W'(FIELD_HL)));  // R6
endmodule

// File: rtl/csync_shape.sv
module csync_shape
  import csync_pkg::*;
#(
  parameter int DIV_BITS = 7,
  parameter int HS_W     = 19,
  parameter int EQ_W     = 9,
  parameter int BROAD_W  = 109,
  parameter int HBL_W    = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_BITS-1:0] cnt_i,
  input  pulse_e              ptype_i,
  input  logic                full_line_i,
  input  logic                vblank_i,
  output logic                sync_no,
  output logic                blank_o
);
  logic low_d, sync_q, blank_q;

  always_comb begin
    unique case (ptype_i)
      PT_HSYNC: low_d = cnt_i < DIV_BITS'(HS_W);
      PT_EQ:    low_d = cnt_i < DIV_BITS'(EQ_W);
      PT_BROAD: low_d = cnt_i < DIV_BITS'(BROAD_W);
      PT_VLOW:  low_d = 1'b1;
      default:  low_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b1;
      blank_q <= 1'b1;
    end else begin
      sync_q  <= !low_d;
      blank_q <= vblank_i || (full_line_i && (cnt_i < DIV_BITS'(HBL_W)));
    end
  end

  assign sync_no = sync_q;
  assign blank_o = blank_q;

  AST_NONE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptype_i == PT_NONE) |=> sync_q);  // R3
  AST_EQ_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptype_i == PT_EQ && cnt_i >= DIV_BITS'(EQ_W)) |=> sync_q);  // R4
  AST_VLOW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptype_i == PT_VLOW) |=> !sync_q);  // R9
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csync_pkg::*;
#(
  parameter int DIV_BITS   = 7,
  parameter int FRAME_HL   = 1250,
  parameter int PROG_LINES = 312,
  parameter int HL_W       = $clog2(FRAME_HL),
  parameter int LINE_W     = HL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  output logic              csync_no,
  output logic              blank_o,
  output logic              field_o,
  output logic [HL_W-1:0]   hline_o,
  output logic [LINE_W-1:0] line_o
);
  logic [DIV_BITS-1:0] cnt;
  logic                tick, vblank;
  logic [HL_W-1:0]     hl;
  pulse_e              ptype;

  csync_div #(.DIV_BITS(DIV_BITS)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt), .tick_o(tick)
  );

  csync_seq #(.FRAME_HL(FRAME_HL), .PROG_LINES(PROG_LINES), .HL_W(HL_W)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .prog_i(prog_i),
    .hl_o(hl), .field_o(field_o), .vblank_o(vblank), .ptype_o(ptype)
  );

  csync_shape #(.DIV_BITS(DIV_BITS)) i_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .ptype_i(ptype),
    .full_line_i(!hl[0]), .vblank_i(vblank),
    .sync_no(csync_no), .blank_o(blank_o)
  );

  assign hline_o = hl;
  assign line_o  = hl[HL_W-1:1];
endmodule

// File: tb/test_csync_gen.sv
`timescale 1ns/1ps
module test_csync_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_i = 1'b0;
  logic       csync_no, blank_o, field_o;
  logic [10:0] hline_o;
  logic [9:0]  line_o;

  int checks = 0;
  int errors = 0;
  int prints = 0;

  csync_gen i_csync_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(prog_i), .csync_no(csync_no),
    .blank_o(blank_o), .field_o(field_o), .hline_o(hline_o), .line_o(line_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp, input int n);
    checks++;
    if (act != exp) begin
      errors++;
      if (prints < 20) begin
        prints++;
        $display("FAIL %s clk=%0d actual=%0d expected=%0d", req, n, act, exp);
      end
    end
  endtask

  // expected sync level and requirement tag for state (mode, h, c)
  function automatic bit exp_low(input bit m, input int h, input int c, output string tag);
    int fi;
    tag = "R3";
    if (m) begin
      if (h < 6) begin
        tag = "R9";
        return (h % 2 == 0) ? 1'b1 : (c < 109);
      end
      tag = "R9";
      return (h % 2 == 0) && (c < 19);
    end
    fi = (h >= 625) ? h - 625 : h;
    if (fi < 5 || (fi >= 10 && fi < 15)) begin
      tag = "R4";
      return c < 9;
    end
    if (fi < 10) begin
      tag = "R5";
      return c < 109;
    end
    return (h % 2 == 0) && (c < 19);
  endfunction

  function automatic bit exp_blank(input bit m, input int h, input int c);
    int fi;
    fi = (!m && h >= 625) ? h - 625 : h;
    return (fi < 50) || ((h % 2 == 0) && c < 48);
  endfunction

  task automatic test_reset(input bit m);
    rst_ni = 1'b0;
    prog_i = m;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 csync", csync_no, 1, 0);
    chk("R1 blank", blank_o, 1, 0);
    chk("R1 field", field_o, 0, 0);
    chk("R1 hline", hline_o, 0, 0);
    chk("R1 line", line_o, 0, 0);
  endtask

  // free-run from reset for n_clk clocks, comparing every output each clock
  task automatic run_raster(input bit m, input int n_clk);
    int lim;
    string tag;
    lim = m ? 624 : 1250;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= n_clk; n++) begin
      int h, c, hp, cp;
      bit lo;
      @(posedge clk_i);
      #1;
      h  = (n / 128) % lim;
      c  = n % 128;
      hp = ((n - 1) / 128) % lim;
      cp = (n - 1) % 128;
      lo = exp_low(m, hp, cp, tag);
      chk(tag, csync_no, !lo, n);                      // R10 registered sync
      chk("R8", blank_o, exp_blank(m, hp, cp), n);
      chk("R2", hline_o, h, n);
      chk("R7", line_o, h / 2, n);
      chk(m ? "R9 field" : "R6", field_o, (!m && h >= 625) ? 1 : 0, n);
      if (c == 0 && h == 0 && n > 0 && !m && hline_o != 0)
        chk("R2 wrap", hline_o, 0, n);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset(1'b0);
    run_raster(1'b0, 160000 + 3000);   // full interlaced frame plus wrap
    test_reset(1'b1);
    run_raster(1'b1, 4000);            // progressive vertical interval
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule